// File: doc/BRIEF.md
# Bus Address Parity Error Injector

This block sits in the address path of an internal bus and corrupts the address parity on purpose, so that the parity checkers downstream can be tested. For each address byte it computes an even parity bit. Before the parity leaves the block, it can flip selected parity bits on exactly one chosen address phase.

Software programs one 32-bit control word. The word holds an arm bit, the ID of the initiator whose request should be hit, and a mask of the parity bits to flip. While the block is armed, it watches the request strobe. The first valid request from the programmed initiator has its parity XORed with the mask in the same cycle as its address phase. The arm bit then drops on the next clock edge, so each arming produces one corrupted phase at most. Software can poll the arm bit to see that the injection has taken place.

Top module: `addr_par_inject`

## Requirements
- R1: After reset, `cfg_rdata` reads 0: the block is disarmed, the ID is 0 and the mask is 0.
- R2: A write with `cfg_we` loads the arm bit from data bit 0, the initiator ID from bits 7:4 and the mask from bits 20:16. From the next cycle, `cfg_rdata` returns these values at the same positions.
- R3: Bits 31:21 and 3:1 of `cfg_rdata` always read 0, whatever was written to them.
- R4: While the block is not injecting, `par_out[i]` equals the XOR of `req_addr[8i+7:8i]` for every i from 0 to 4.
- R5: When the block is armed, `req_valid` is high and `req_id` equals the programmed ID, `par_out` equals the generated parity XORed with the mask in that same cycle. Mask bit 16 flips parity bit 0, bit 17 flips parity bit 1, and so on up to parity bit 4.
- R6: A valid request whose ID differs from the programmed ID gets correct parity and leaves the block armed.
- R7: After a matching armed request, the arm bit reads 0 in the next cycle, and later requests from that initiator get correct parity.
- R8: A write with data bit 0 set, made in the same cycle as a matching request, leaves the block armed, with the newly written ID and mask.
- R9: A write with data bit 0 clear disarms the block, so that no later request is corrupted.
- R10: With a zero mask, a matching armed request gets correct parity and still clears the arm bit.
- R11: With `req_valid` low, the parity is never corrupted and the arm bit is kept, even when `req_id` matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 32 | Control word to write |
| cfg_rdata | output | 32 | Current control word, with the live arm bit |
| req_valid | input | 1 | Address phase strobe |
| req_id | input | 4 | Initiator ID of the current request |
| req_addr | input | 40 | Address of the current request |
| par_out | output | 5 | Byte parity driven onto the bus, corrupted when injecting |

## Verification
Two functions can fall in the same cycle: the hardware clear of the arm bit after a hit, and a software write that sets the arm bit again. The bench provokes this by arming the block and then, in one cycle, issuing a matching request together with a write of a new word that has bit 0 set. It then checks three things: the hit cycle is corrupted with the old mask, the read value in the following cycle is still armed and carries the new mask, and the next matching request is corrupted with that new mask.

// File: rtl/addr_par_inject.sv
module addr_par_inject #(
  parameter int ADDR_W   = 40,
  parameter int ID_W     = 4,
  parameter int REG_W    = 32,
  parameter int ARM_BIT  = 0,
  parameter int ID_LSB   = 4,
  parameter int MASK_LSB = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [REG_W-1:0]  cfg_wdata,
  output logic [REG_W-1:0]  cfg_rdata,
  input  logic              req_valid,
  input  logic [ID_W-1:0]   req_id,
  input  logic [ADDR_W-1:0] req_addr,
  output logic [ADDR_W/8-1:0] par_out
);
  localparam int PAR_W = ADDR_W / 8;

  logic              arm_q;
  logic [ID_W-1:0]   id_q;
  logic [PAR_W-1:0]  mask_q;
  logic [PAR_W-1:0]  gen_par;
  logic              hit;
  logic              unused_wdata;

  for (genvar g = 0; g < PAR_W; g++) begin : g_par
    assign gen_par[g] = ^req_addr[8*g +: 8];
  end

  assign hit     = arm_q && req_valid && (req_id == id_q);
  assign par_out = gen_par ^ (hit ? mask_q : '0);
  assign unused_wdata = ^cfg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q  <= 1'b0;
      id_q   <= '0;
      mask_q <= '0;
    end else if (cfg_we) begin
      arm_q  <= cfg_wdata[ARM_BIT];
      id_q   <= cfg_wdata[ID_LSB +: ID_W];
      mask_q <= cfg_wdata[MASK_LSB +: PAR_W];
    end else if (hit) begin
      arm_q  <= 1'b0;
    end
  end

  always_comb begin
    cfg_rdata                     = '0;
    cfg_rdata[ARM_BIT]            = arm_q;
    cfg_rdata[ID_LSB +: ID_W]     = id_q;
    cfg_rdata[MASK_LSB +: PAR_W]  = mask_q;
  end
endmodule

// File: rtl/addr_par_inject_chk.sv
module addr_par_inject_chk #(
  parameter int ADDR_W   = 40,
  parameter int ID_W     = 4,
  parameter int REG_W    = 32,
  parameter int ARM_BIT  = 0,
  parameter int ID_LSB   = 4,
  parameter int MASK_LSB = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic [REG_W-1:0]  cfg_wdata,
  input logic [REG_W-1:0]  cfg_rdata,
  input logic              req_valid,
  input logic [ID_W-1:0]   req_id,
  input logic [ADDR_W-1:0] req_addr,
  input logic [ADDR_W/8-1:0] par_out
);
  localparam int PAR_W = ADDR_W / 8;

  logic [PAR_W-1:0] ref_par;
  logic [REG_W-1:0] rsv_mask;
  logic             armed, match;

  always_comb begin
    for (int i = 0; i < PAR_W; i++) ref_par[i] = ^req_addr[8*i +: 8];
    rsv_mask = '1;
    rsv_mask[ARM_BIT] = 1'b0;
    rsv_mask[ID_LSB +: ID_W] = '0;
    rsv_mask[MASK_LSB +: PAR_W] = '0;
  end

  assign armed = cfg_rdata[ARM_BIT];
  assign match = req_valid && (req_id == cfg_rdata[ID_LSB +: ID_W]);

  p_reserved_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata & rsv_mask) == '0);

  p_clean_when_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(armed && match) |-> par_out == ref_par);

  p_hit_flips_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && match) |-> par_out == (ref_par ^ cfg_rdata[MASK_LSB +: PAR_W]));

  p_other_keeps_arm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !match && !cfg_we) |=> cfg_rdata[ARM_BIT]);

  p_disarm_after_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && match && !cfg_we) |=> !cfg_rdata[ARM_BIT]);

  p_write_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_wdata[ARM_BIT]) |=> cfg_rdata[ARM_BIT]);

  p_write_disarms_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_wdata[ARM_BIT]) |=> !cfg_rdata[ARM_BIT]);
endmodule

bind addr_par_inject addr_par_inject_chk #(
  .ADDR_W(ADDR_W), .ID_W(ID_W), .REG_W(REG_W),
  .ARM_BIT(ARM_BIT), .ID_LSB(ID_LSB), .MASK_LSB(MASK_LSB)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_id(req_id),
  .req_addr(req_addr), .par_out(par_out)
);

// File: tb/addr_par_inject_tb_top.sv
module addr_par_inject_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic [3:0]  req_id = '0;
  logic [39:0] req_addr = '0;
  logic [4:0]  par_out;

  int vectors = 0, miscompares = 0, cycles = 0;
  bit done = 1'b0;

  logic [4:0]  q_par[$];
  logic [31:0] q_rd[$];
  string       q_tag[$];

  logic       m_arm = 1'b0;
  logic [3:0] m_id = '0;
  logic [4:0] m_mask = '0;

  always #2 clk = ~clk;

  addr_par_inject dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_id(req_id),
    .req_addr(req_addr), .par_out(par_out)
  );

  function automatic logic [4:0] byte_par(logic [39:0] a);
    logic [4:0] p;
    for (int i = 0; i < 5; i++) p[i] = ^a[8*i +: 8];
    return p;
  endfunction

  task automatic step(input bit we, input logic [31:0] wd, input bit v,
                      input logic [3:0] id, input logic [39:0] addr, input string tag);
    bit hit;
    @(negedge clk);
    cfg_we = we; cfg_wdata = wd; req_valid = v; req_id = id; req_addr = addr;
    hit = m_arm && v && (id == m_id);
    q_par.push_back(byte_par(addr) ^ (hit ? m_mask : 5'd0));
    q_rd.push_back({11'd0, m_mask, 8'd0, m_id, 3'd0, m_arm});
    q_tag.push_back(tag);
    if (we) begin
      m_arm = wd[0]; m_id = wd[7:4]; m_mask = wd[20:16];
    end else if (hit) m_arm = 1'b0;
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #1;
      while (q_par.size() > 0) begin
        logic [4:0] ep; logic [31:0] er; string t;
        ep = q_par.pop_front(); er = q_rd.pop_front(); t = q_tag.pop_front();
        vectors++;
        if (par_out !== ep || cfg_rdata !== er) begin
          miscompares++;
          $display("FAIL %s: par_out=%h rdata=%h expected par_out=%h rdata=%h",
                   t, par_out, cfg_rdata, ep, er);
        end
      end
    end
  end

  initial begin : watchdog
    while (!done && cycles < 5000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin : driver
    #5;
    vectors++;
    if (cfg_rdata !== 32'd0 || par_out !== 5'd0) begin
      miscompares++;
      $display("FAIL R1: rdata=%h expected 0", cfg_rdata);
    end
    @(negedge clk); rst_n = 1'b1;
    step(0, 0, 0, 0, 40'h0, "R1");
    // R4: clean parity with block disarmed
    for (int k = 0; k < 8; k++)
      step(0, 0, 1, 4'(k), 40'hFF_01_03_07_80 ^ (40'h13_57_9B_DF_21 * 40'(k)), "R4");
    // R2 R3: write with reserved bits set
    step(1, 32'hFFF5_005F, 0, 0, 40'h0, "R2");
    step(0, 0, 0, 0, 40'h12_34_56_78_9A, "R3");
    // R6: other initiator passes, arm kept
    step(0, 0, 1, 4'd3, 40'hA5_00_FF_01_77, "R6");
    step(0, 0, 1, 4'd9, 40'h01_02_04_08_10, "R6");
    // R11: matching ID without strobe
    step(0, 0, 0, 4'd5, 40'hC3_3C_81_18_E7, "R11");
    // R5: hit
    step(0, 0, 1, 4'd5, 40'h00_11_22_33_44, "R5");
    // R7: disarmed now, clean
    step(0, 0, 1, 4'd5, 40'h00_11_22_33_44, "R7");
    step(0, 0, 1, 4'd5, 40'hDE_AD_BE_EF_01, "R7");
    // R8: hit together with re-arm write, new mask
    step(1, 32'h000A_0021, 0, 0, 40'h0, "R8");
    step(1, 32'h001F_0071, 1, 4'd2, 40'h55_AA_55_AA_0F, "R8");
    step(0, 0, 0, 0, 40'h0, "R8");
    step(0, 0, 1, 4'd7, 40'h98_76_54_32_10, "R8");
    step(0, 0, 0, 0, 40'h0, "R7");
    // R9: software disarm
    step(1, 32'h0003_0041, 0, 0, 40'h0, "R9");
    step(1, 32'h0003_0040, 1, 4'd4, 40'hF0_0F_F0_0F_33, "R9");
    step(0, 0, 1, 4'd4, 40'hF0_0F_F0_0F_33, "R9");
    // R10: zero mask consumes arm without corruption
    step(1, 32'h0000_00B1, 0, 0, 40'h0, "R10");
    step(0, 0, 1, 4'd11, 40'h77_66_55_44_33, "R10");
    step(0, 0, 0, 0, 40'h0, "R10");
    step(0, 0, 0, 0, 40'h0, "R10");
    @(negedge clk); #2;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule